// File: doc/BRIEF.md
# Per-Pixel Fragment Merge Unit

This block is the last stage of a raster pipeline. It accepts one fragment per cycle, carrying a pixel position, a depth, an RGBA colour and an 8-bit stencil reference. For each fragment it reads the stored colour, depth and stencil of that pixel. It runs a stencil test and a strict less-than depth test. When both tests pass, it writes back the updated buffers, blending the colour with the stored colour if blending is enabled.

The colour, depth and stencil buffers are held inside the block and share the same resolution. A clear command sweeps all pixels back to their initial state. A registered scan port reads out any pixel. The configuration (stencil compare, stencil write operation, depth-write enable and blend enable) is captured together with each fragment. A new fragment to the pixel still being written back waits one cycle, so it never reads a stale value.

Top module: `frag_merge`

## Requirements
- R1: After reset, and after a clear, every pixel holds colour 0, depth all ones and stencil 0. A clear pulse makes frag_ready low for exactly NPIX = 2^(XW+YW) cycles while it sweeps the buffers.
- R2: The depth test passes only when the fragment depth is strictly smaller than the stored depth. An equal depth fails.
- R3: A fragment that fails either test changes no buffer, and its res_kept is 0.
- R4: With cfg_zwe = 0, a passing fragment updates colour and stencil but leaves the stored depth unchanged.
- R5: cfg_sfunc selects the stencil compare of frag_sref against the stored stencil: 0 always passes, 1 passes when equal, 2 passes when not equal, 3 never passes.
- R6: cfg_sop selects the stencil write on a passing fragment: 0 keeps the stored value, 1 writes frag_sref, 2 writes zero. A failing fragment never writes the stencil.
- R7: With cfg_blend_en = 1, each byte channel c (bits 8c+7:8c, with alpha a in bits 31:24) becomes (a*src + (255-a)*dst + 127)/255. So alpha 255 gives exactly the source and alpha 0 gives exactly the destination.
- R8: With cfg_blend_en = 0, a passing fragment writes its colour unchanged.
- R9: A fragment to the same pixel as the fragment accepted in the previous cycle waits exactly one cycle. A fragment to a different pixel does not wait.
- R10: res_valid pulses two cycles after the accepting edge, and res_kept shows whether that fragment passed both tests.
- R11: scan_rgba, scan_z and scan_sten show the pixel at {scan_y, scan_x} one cycle after the address is applied.
- R12: For opaque fragments with depth writes, the final colour and depth of a pixel do not depend on the order in which the fragments arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_req | input | 1 | Start a buffer clear |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment can be accepted |
| frag_x | input | XW | Pixel column |
| frag_y | input | YW | Pixel row |
| frag_z | input | ZW | Fragment depth |
| frag_rgba | input | 32 | Colour; alpha in bits 31:24 |
| frag_sref | input | 8 | Stencil reference |
| cfg_sfunc | input | 2 | Stencil compare select |
| cfg_sop | input | 2 | Stencil write select |
| cfg_zwe | input | 1 | Depth write enable |
| cfg_blend_en | input | 1 | Blend enable |
| res_valid | output | 1 | Fragment result strobe |
| res_kept | output | 1 | Fragment passed and was written |
| scan_x | input | XW | Scan column |
| scan_y | input | YW | Scan row |
| scan_rgba | output | 32 | Stored colour at scan pixel |
| scan_z | output | ZW | Stored depth at scan pixel |
| scan_sten | output | 8 | Stored stencil at scan pixel |

## Verification
The depth path is driven with smaller, equal and larger depths, so the strict compare is separated from a less-or-equal one. The stencil path is set up with a marker pixel and unmarked pixels, so the equal compare, the not-equal compare and each write operation produce different final stencil and colour values. Blending is tried with alpha 255, alpha 0 and a mid alpha, which separates exact pass-through from the rounded mix. The same three opaque fragments are sent in two orders, and same-pixel and different-pixel back-to-back pairs are sent, which separates a correct stall from a missing or needless one.

// File: rtl/frag_merge.sv
module frag_merge #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  input  logic          frag_valid,
  output logic          frag_ready,
  input  logic [XW-1:0] frag_x,
  input  logic [YW-1:0] frag_y,
  input  logic [ZW-1:0] frag_z,
  input  logic [31:0]   frag_rgba,
  input  logic [7:0]    frag_sref,
  input  logic [1:0]    cfg_sfunc,
  input  logic [1:0]    cfg_sop,
  input  logic          cfg_zwe,
  input  logic          cfg_blend_en,
  output logic          res_valid,
  output logic          res_kept,
  input  logic [XW-1:0] scan_x,
  input  logic [YW-1:0] scan_y,
  output logic [31:0]   scan_rgba,
  output logic [ZW-1:0] scan_z,
  output logic [7:0]    scan_sten
);
  localparam int AW = XW + YW;
  localparam int NPIX = 1 << AW;

  logic [31:0]   cbuf [NPIX];
  logic [ZW-1:0] zbuf [NPIX];
  logic [7:0]    sbuf [NPIX];

  logic          s1_v, s1_zwe, s1_ben;
  logic [AW-1:0] s1_a;
  logic [ZW-1:0] s1_z, d_z;
  logic [31:0]   s1_rgba, d_rgba, blended;
  logic [7:0]    s1_sref, d_s, new_s;
  logic [1:0]    s1_sfunc, s1_sop;
  logic          clearing, s_pass, pass;
  logic [AW-1:0] clr_cnt;

  wire [AW-1:0] in_a = {frag_y, frag_x};
  assign frag_ready = !clearing && !clr_req && !(s1_v && s1_a == in_a);
  wire accept = frag_valid && frag_ready;

  always_comb begin
    case (s1_sfunc)
      2'd0:    s_pass = 1'b1;
      2'd1:    s_pass = (s1_sref == d_s);
      2'd2:    s_pass = (s1_sref != d_s);
      default: s_pass = 1'b0;
    endcase
    case (s1_sop)
      2'd1:    new_s = s1_sref;
      2'd2:    new_s = 8'd0;
      default: new_s = d_s;
    endcase
  end

  assign pass = s_pass && (s1_z < d_z);

  wire [7:0] alpha = s1_rgba[31:24];
  for (genvar c = 0; c < 4; c++) begin : g_ch
    wire [16:0] mix = 17'(alpha) * 17'(s1_rgba[8*c +: 8])
                    + 17'(8'd255 - alpha) * 17'(d_rgba[8*c +: 8]) + 17'd127;
    assign blended[8*c +: 8] = 8'(mix / 17'd255);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) begin
        cbuf[i] <= '0;
        zbuf[i] <= '1;
        sbuf[i] <= '0;
      end
      s1_v <= 1'b0;
      clearing <= 1'b0;
      clr_cnt <= '0;
      res_valid <= 1'b0;
      res_kept <= 1'b0;
      scan_rgba <= '0;
      scan_z <= '0;
      scan_sten <= '0;
    end else begin
      res_valid <= s1_v;
      res_kept <= s1_v && pass;
      s1_v <= accept;
      if (accept) begin
        s1_a <= in_a;
        s1_z <= frag_z;
        s1_rgba <= frag_rgba;
        s1_sref <= frag_sref;
        s1_sfunc <= cfg_sfunc;
        s1_sop <= cfg_sop;
        s1_zwe <= cfg_zwe;
        s1_ben <= cfg_blend_en;
        d_rgba <= cbuf[in_a];
        d_z <= zbuf[in_a];
        d_s <= sbuf[in_a];
      end
      if (clearing) begin
        cbuf[clr_cnt] <= '0;
        zbuf[clr_cnt] <= '1;
        sbuf[clr_cnt] <= '0;
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == AW'(NPIX - 1)) clearing <= 1'b0;
      end else if (clr_req) begin
        clearing <= 1'b1;
        clr_cnt <= '0;
      end
      if (s1_v && pass) begin
        cbuf[s1_a] <= s1_ben ? blended : s1_rgba;
        sbuf[s1_a] <= new_s;
        if (s1_zwe) zbuf[s1_a] <= s1_z;
      end
      scan_rgba <= cbuf[{scan_y, scan_x}];
      scan_z <= zbuf[{scan_y, scan_x}];
      scan_sten <= sbuf[{scan_y, scan_x}];
    end
  end
endmodule

// File: rtl/frag_merge_chk.sv
module frag_merge_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic          clearing,
  input logic          s1_v,
  input logic [AW-1:0] s1_a,
  input logic [AW-1:0] in_a,
  input logic          res_valid,
  input logic          res_kept
);
  a_r9_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && frag_ready && s1_v) |-> (in_a != s1_a));
  a_r1_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !frag_ready);
  a_r10_accept_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && frag_ready) |=> s1_v);
  a_r10_report_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(s1_v));
  a_r3_kept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_kept |-> res_valid);
endmodule

bind frag_merge frag_merge_chk #(.AW(XW + YW)) chk_i (
  .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
  .clearing(clearing), .s1_v(s1_v), .s1_a(s1_a), .in_a(in_a),
  .res_valid(res_valid), .res_kept(res_kept)
);

// File: tb/frag_merge_tb.sv
module frag_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 3, YW = 3, ZW = 16;
  localparam int NPIX = 1 << (XW + YW);

  logic clk = 0, rst_n = 0, clr_req = 0, frag_valid = 0, frag_ready;
  logic [XW-1:0] frag_x = 0, scan_x = 0;
  logic [YW-1:0] frag_y = 0, scan_y = 0;
  logic [ZW-1:0] frag_z = 0, scan_z;
  logic [31:0] frag_rgba = 0, scan_rgba;
  logic [7:0] frag_sref = 0, scan_sten;
  logic [1:0] cfg_sfunc = 0, cfg_sop = 0;
  logic cfg_zwe = 1, cfg_blend_en = 0, res_valid, res_kept;
  int errors = 0, checks = 0, stalls = 0;
  logic last_rv, last_rk;

  frag_merge #(.XW(XW), .YW(YW), .ZW(ZW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int z, input logic [31:0] c,
                      input int sref, input int sf, input int so, input bit zwe, input bit ben);
    @(negedge clk);
    frag_valid = 1; frag_x = XW'(x); frag_y = YW'(y); frag_z = ZW'(z);
    frag_rgba = c; frag_sref = 8'(sref); cfg_sfunc = 2'(sf); cfg_sop = 2'(so);
    cfg_zwe = zwe; cfg_blend_en = ben; stalls = 0;
    #1;
    while (!frag_ready) begin stalls++; @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_one(input int x, input int y, input int z, input logic [31:0] c,
                          input int sref, input int sf, input int so, input bit zwe, input bit ben);
    send(x, y, z, c, sref, sf, so, zwe, ben);
    @(negedge clk); frag_valid = 0;
    @(negedge clk); last_rv = res_valid; last_rk = res_kept;
  endtask

  task automatic peek(input int x, input int y);
    @(negedge clk); scan_x = XW'(x); scan_y = YW'(y);
    @(negedge clk);
  endtask

  function automatic logic [31:0] blend(input logic [31:0] s, input logic [31:0] d);
    logic [31:0] r;
    int a = int'(s[31:24]);
    for (int c = 0; c < 4; c++)
      r[8*c +: 8] = 8'((a * int'(s[8*c +: 8]) + (255 - a) * int'(d[8*c +: 8]) + 127) / 255);
    return r;
  endfunction

  task automatic do_clear();
    int low = 0;
    @(negedge clk); clr_req = 1;
    @(negedge clk); clr_req = 0;
    while (!frag_ready) begin low++; @(negedge clk); end
    chk("R1 clear busy cycles", low, NPIX);
  endtask

  task automatic t_reset();
    peek(5, 2);
    chk("R1 reset colour", scan_rgba, 0);
    chk("R1 reset depth", 32'(scan_z), 32'hFFFF);
    chk("R1 reset stencil", 32'(scan_sten), 0);
  endtask

  task automatic t_depth();
    send_one(0, 0, 100, 32'hFF112233, 0, 0, 0, 1, 0);
    chk("R10 res_valid", 32'(last_rv), 1);
    chk("R10 res_kept pass", 32'(last_rk), 1);
    send_one(0, 0, 100, 32'hFF445566, 0, 0, 0, 1, 0);
    chk("R2 equal depth rejected", 32'(last_rk), 0);
    send_one(0, 0, 150, 32'hFF778899, 0, 0, 1, 1, 0);
    chk("R3 fail kept", 32'(last_rk), 0);
    peek(0, 0);
    chk("R3 colour unchanged", scan_rgba, 32'hFF112233);
    chk("R3 stencil unchanged", 32'(scan_sten), 0);
    chk("R2 depth", 32'(scan_z), 100);
    send_one(0, 0, 40, 32'hFFAABBCC, 0, 0, 0, 0, 0);
    peek(0, 0);
    chk("R4 colour written", scan_rgba, 32'hFFAABBCC);
    chk("R4 depth kept", 32'(scan_z), 100);
  endtask

  task automatic t_stencil();
    send_one(1, 1, 500, 32'hFF000001, 1, 0, 1, 1, 0);
    peek(1, 1);
    chk("R6 replace", 32'(scan_sten), 1);
    send_one(1, 1, 400, 32'hFF000002, 1, 1, 0, 1, 0);
    chk("R5 equal pass", 32'(last_rk), 1);
    peek(1, 1);
    chk("R6 keep", 32'(scan_sten), 1);
    send_one(2, 2, 400, 32'hFF000003, 1, 1, 1, 1, 0);
    chk("R5 equal fail", 32'(last_rk), 0);
    peek(2, 2);
    chk("R6 no write on fail", 32'(scan_sten), 0);
    chk("R5 equal fail colour", scan_rgba, 0);
    send_one(2, 2, 400, 32'hFF000004, 1, 2, 1, 1, 0);
    chk("R5 not-equal pass", 32'(last_rk), 1);
    send_one(1, 1, 300, 32'hFF000005, 1, 2, 0, 1, 0);
    chk("R5 not-equal fail", 32'(last_rk), 0);
    send_one(1, 1, 300, 32'hFF000006, 0, 3, 0, 1, 0);
    chk("R5 never", 32'(last_rk), 0);
    send_one(1, 1, 300, 32'hFF000007, 9, 0, 2, 1, 0);
    peek(1, 1);
    chk("R6 zero", 32'(scan_sten), 0);
    chk("R5 always colour", scan_rgba, 32'hFF000007);
  endtask

  task automatic t_blend();
    logic [31:0] dst = 32'hFF4080C0, src;
    send_one(3, 0, 900, dst, 0, 0, 0, 0, 0);
    src = 32'h80FF2010;
    send_one(3, 0, 800, src, 0, 0, 0, 0, 1);
    peek(3, 0);
    chk("R7 mid alpha", scan_rgba, blend(src, dst));
    dst = scan_rgba;
    send_one(3, 0, 800, 32'h00123456, 0, 0, 0, 0, 1);
    peek(3, 0);
    chk("R7 alpha 0 keeps dst", scan_rgba, dst);
    send_one(3, 0, 800, 32'hFF9A8B7C, 0, 0, 0, 0, 1);
    peek(3, 0);
    chk("R7 alpha 255 gives src", scan_rgba, 32'hFF9A8B7C);
    send_one(3, 0, 800, 32'h10ABCDEF, 0, 0, 0, 0, 0);
    peek(3, 0);
    chk("R8 blend off", scan_rgba, 32'h10ABCDEF);
  endtask

  task automatic t_hazard();
    send(5, 5, 300, 32'hFF111111, 0, 0, 0, 1, 0);
    send(5, 5, 200, 32'hFF222222, 0, 0, 0, 1, 0);
    chk("R9 same pixel stall", stalls, 1);
    send(6, 6, 300, 32'hFF333333, 0, 0, 0, 1, 0);
    chk("R9 stall after prior", stalls, 0);
    send(7, 6, 300, 32'hFF444444, 0, 0, 0, 1, 0);
    chk("R9 different pixel no stall", stalls, 0);
    @(negedge clk); frag_valid = 0;
    repeat (2) @(negedge clk);
    peek(5, 5);
    chk("R9 second write seen", scan_rgba, 32'hFF222222);
    chk("R11 scan depth", 32'(scan_z), 200);
  endtask

  task automatic t_order();
    send_one(3, 3, 100, 32'hFFAA0000, 0, 0, 0, 1, 0);
    send_one(3, 3, 50, 32'hFF00BB00, 0, 0, 0, 1, 0);
    send_one(3, 3, 200, 32'hFF0000CC, 0, 0, 0, 1, 0);
    send_one(4, 4, 200, 32'hFF0000CC, 0, 0, 0, 1, 0);
    send_one(4, 4, 50, 32'hFF00BB00, 0, 0, 0, 1, 0);
    send_one(4, 4, 100, 32'hFFAA0000, 0, 0, 0, 1, 0);
    peek(3, 3);
    chk("R12 order A colour", scan_rgba, 32'hFF00BB00);
    chk("R12 order A depth", 32'(scan_z), 50);
    peek(4, 4);
    chk("R12 order B colour", scan_rgba, 32'hFF00BB00);
    chk("R12 order B depth", 32'(scan_z), 50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_depth();
    t_stencil();
    t_blend();
    t_hazard();
    do_clear();
    peek(5, 5);
    chk("R1 cleared colour", scan_rgba, 0);
    chk("R1 cleared depth", 32'(scan_z), 32'hFFFF);
    t_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule